// File: doc/BRIEF.md
# UART receive FIFO with status

This block sits between a UART bit-level receiver and the register read path. It takes each received byte, or a break indication, and buffers it. With the enable bit set it works as a circular FIFO of `DEPTH` entries. With the enable bit clear it keeps only the most recent byte in a single holding register. A read strobe on the data port returns the oldest buffered byte one cycle later. Reading an empty FIFO is reported as an error and returns zero.

Alongside the data path the block keeps a packed status word: an entry count, plus a separate full flag that is set in place of a count equal to the depth. It also drives a data-ready flag and a four-bit error status register that clears when read. Two one-cycle event outputs, one for received bytes and one for errors, feed an interrupt controller outside this block. The same control write that sets the enable bit can also flush the receive FIFO or request a flush of a transmit FIFO located elsewhere. Both flush bits act once and then read back as zero.

Top module: `uart_rx_buffer`

## Requirements
- R1: After a synchronous reset the FIFO is disabled, `ctrl_rdata` is 0, `fifo_status` is 0, `data_ready` is 0, `err_rdata` is 0, and both event outputs are low.
- R2: A control write stores bit 0 (FIFO enable), which reads back on `ctrl_rdata[0]`. Bit 1 empties the receive FIFO, so the count becomes 0 and `data_ready` drops. Bit 2 gives a one-cycle `tx_flush` pulse. Bits 1 and 2 always read back as 0.
- R3: With the FIFO enabled, bytes come out in arrival order and up to `DEPTH` (default 16) are held. `rd_data` is valid, with `rd_valid` high, in the cycle after `rd_en`.
- R4: `fifo_status[7:0]` holds the number of stored bytes and `fifo_status[8]` is the full flag. When the FIFO holds `DEPTH` bytes, bits [7:0] read 0 and bit 8 reads 1.
- R5: A read with the FIFO enabled and empty returns 0 and pulses `err_evt`. It sets no error status bit.
- R6: With the FIFO enabled, `data_ready` is high while at least one byte is stored and falls when the read that takes the last byte completes.
- R7: With the FIFO disabled, each received byte overwrites the holding register and sets `data_ready`. A read returns that byte and clears `data_ready`.
- R8: A byte arriving while the FIFO is full, with no read in the same cycle, is dropped. The stored contents stay unchanged, `err_evt` pulses and error bit 0 (overrun) is set.
- R9: `rx_evt` pulses for one cycle after every byte that is stored, in both modes, and stays low for a dropped byte.
- R10: `rx_break` stores a zero byte as an ordinary received byte, sets error bit 3 and pulses `err_evt`.
- R11: `rx_perr` or `rx_ferr` given with `rx_valid` sets error bit 1 (parity) or bit 2 (frame) and pulses `err_evt`. The byte is still stored.
- R12: `err_rd` returns the accumulated error bits on `err_rdata` one cycle later and clears them. An error that arrives in the same cycle as the read is kept for the next read.
- R13: A store and a read in the same cycle leave the count unchanged. When the FIFO is full, a byte that arrives together with a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 3 | Control write data: bit 0 enable, bit 1 receive flush, bit 2 transmit flush |
| ctrl_rdata | output | 3 | Control readback (flush bits read 0) |
| tx_flush | output | 1 | One-cycle transmit FIFO flush request |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | DW | Received byte |
| rx_perr | input | 1 | Parity error flag, qualified by rx_valid |
| rx_ferr | input | 1 | Framing error flag, qualified by rx_valid |
| rx_break | input | 1 | Break condition detected |
| rd_en | input | 1 | Data register read strobe |
| rd_data | output | DW | Read data, valid the cycle after rd_en |
| rd_valid | output | 1 | Marks rd_data valid |
| fifo_status | output | 9 | Count [7:0] and full flag [8] |
| data_ready | output | 1 | Receive data available |
| err_rd | input | 1 | Error status read strobe (clears the register) |
| err_rdata | output | 4 | Error bits read back: overrun 0, parity 1, frame 2, break 3 |
| rx_evt | output | 1 | Receive event pulse |
| err_evt | output | 1 | Error event pulse |

## Verification
Some properties are checked on every cycle by the assertions. The count never goes past the depth. The buffer is never pushed when full without a matching pop, and never popped when empty. A combined push and pop keeps the count. A flush empties the buffer. A read of an empty FIFO yields zero with an error event. A stored byte always produces a receive event. Error bits stay set until read, and a bit raised during a read is kept. Other behaviour can only be shown by the directed scenarios: the order in which bytes come out, the count/full packing of the status word at exactly the depth, overrun on the byte after the last one that fits, break bytes reading back as zero, and holding-register mode keeping only the latest byte.

// File: rtl/uart_rxb_pkg.sv
package uart_rxb_pkg;
  // error status bit positions (software decodes these)
  localparam int ERR_OVR = 0;
  localparam int ERR_PAR = 1;
  localparam int ERR_FRM = 2;
  localparam int ERR_BRK = 3;
  localparam int ERRW    = 4;
  // control bit positions
  localparam int CTL_EN    = 0;
  localparam int CTL_RXRST = 1;
  localparam int CTL_TXRST = 2;
  localparam int CTLW      = 3;
  localparam int STATW     = 9;

  typedef enum logic [1:0] {SRC_NONE, SRC_FIFO, SRC_ZERO, SRC_HOLD} rd_src_e;
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] cnt,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] pop_q;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    if (p == AW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push && !flush) mem[wp_q] <= push_data;
    if (pop) pop_q <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= bump(wp_q);
      if (pop)  rp_q <= bump(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign pop_data = pop_q;
  assign cnt      = cnt_q;
  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(DEPTH));
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    !(push && full && !pop));
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));
  assert_pushpop_keep_R13: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !flush) |=> cnt_q == $past(cnt_q));
  assert_flush_empty_R2: assert property (@(posedge clk) disable iff (rst)
    flush |=> cnt_q == '0);
endmodule

// File: rtl/rxb_errstat.sv
module rxb_errstat #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_bits,
  input  logic         extra_evt,
  input  logic         rd,
  output logic [W-1:0] rdata,
  output logic         evt
);
  logic [W-1:0] q;
  logic [W-1:0] rdata_q;
  logic         evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q       <= '0;
      rdata_q <= '0;
      evt_q   <= 1'b0;
    end else begin
      evt_q <= (|set_bits) || extra_evt;
      if (rd) begin
        rdata_q <= q;
        q       <= set_bits;
      end else begin
        q <= q | set_bits;
      end
    end
  end

  assign rdata = rdata_q;
  assign evt   = evt_q;

  assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (!rd && set_bits != '0) |=> (q & $past(set_bits)) == $past(set_bits));
  assert_keep_on_read_R12: assert property (@(posedge clk) disable iff (rst)
    rd |=> q == $past(set_bits));
  assert_set_evt_R11: assert property (@(posedge clk) disable iff (rst)
    (set_bits != '0) |=> evt);
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rxb_pkg::*;
#(
  parameter int DEPTH = 16,  // at most 255 so the count fits the status field
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctrl_wr,
  input  logic [CTLW-1:0]  ctrl_wdata,
  output logic [CTLW-1:0]  ctrl_rdata,
  output logic             tx_flush,
  input  logic             rx_valid,
  input  logic [DW-1:0]    rx_byte,
  input  logic             rx_perr,
  input  logic             rx_ferr,
  input  logic             rx_break,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid,
  output logic [STATW-1:0] fifo_status,
  output logic             data_ready,
  input  logic             err_rd,
  output logic [ERRW-1:0]  err_rdata,
  output logic             rx_evt,
  output logic             err_evt
);
  logic          en_q, tx_flush_q, hold_rdy_q, rx_evt_q;
  logic [DW-1:0] hold_q, hold_out_q;
  rd_src_e       src_q;

  logic          flush, push_req, pop_ok, empty_rd, fifo_push, drop, hold_push, accepted;
  logic [DW-1:0] push_byte, pop_data;
  logic [CW-1:0] cnt;
  logic          full, empty;
  logic [ERRW-1:0] err_set;

  assign flush     = ctrl_wr && ctrl_wdata[CTL_RXRST];
  assign push_req  = rx_valid || rx_break;
  assign push_byte = rx_break ? '0 : rx_byte;
  assign pop_ok    = rd_en && en_q && !empty;
  assign empty_rd  = rd_en && en_q && empty;
  assign fifo_push = en_q && push_req && !flush && (!full || pop_ok);
  assign drop      = en_q && push_req && !flush && full && !pop_ok;
  assign hold_push = !en_q && push_req;
  assign accepted  = fifo_push || hold_push;

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = drop;
    err_set[ERR_PAR] = rx_valid && !rx_break && rx_perr;
    err_set[ERR_FRM] = rx_valid && !rx_break && rx_ferr;
    err_set[ERR_BRK] = rx_break;
  end

  rxb_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .flush(flush), .push(fifo_push), .push_data(push_byte),
    .pop(pop_ok), .pop_data(pop_data), .cnt(cnt), .full(full), .empty(empty)
  );

  rxb_errstat #(.W(ERRW)) u_err (
    .clk(clk), .rst(rst), .set_bits(err_set), .extra_evt(empty_rd), .rd(err_rd),
    .rdata(err_rdata), .evt(err_evt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      tx_flush_q <= 1'b0;
      hold_q     <= '0;
      hold_out_q <= '0;
      hold_rdy_q <= 1'b0;
      src_q      <= SRC_NONE;
      rx_evt_q   <= 1'b0;
    end else begin
      tx_flush_q <= ctrl_wr && ctrl_wdata[CTL_TXRST];
      if (ctrl_wr) en_q <= ctrl_wdata[CTL_EN];
      rx_evt_q <= accepted;
      if (hold_push) begin
        hold_q     <= push_byte;
        hold_rdy_q <= 1'b1;
      end else if (rd_en && !en_q) begin
        hold_rdy_q <= 1'b0;
      end
      if (rd_en && !en_q) hold_out_q <= hold_q;
      if (!rd_en)      src_q <= SRC_NONE;
      else if (!en_q)  src_q <= SRC_HOLD;
      else if (empty)  src_q <= SRC_ZERO;
      else             src_q <= SRC_FIFO;
    end
  end

  always_comb begin
    case (src_q)
      SRC_FIFO: rd_data = pop_data;
      SRC_HOLD: rd_data = hold_out_q;
      default:  rd_data = '0;
    endcase
  end

  assign rd_valid    = (src_q != SRC_NONE);
  assign ctrl_rdata  = {{(CTLW-1){1'b0}}, en_q};
  assign tx_flush    = tx_flush_q;
  assign rx_evt      = rx_evt_q;
  assign data_ready  = en_q ? !empty : hold_rdy_q;
  assign fifo_status = {full, full ? 8'h00 : 8'(cnt)};

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
    empty_rd |=> (rd_valid && rd_data == '0 && err_evt));
  assert_accept_evt_R9: assert property (@(posedge clk) disable iff (rst)
    accepted |=> rx_evt);
  assert_last_read_R6: assert property (@(posedge clk) disable iff (rst)
    (pop_ok && cnt == CW'(1) && !fifo_push && !ctrl_wr) |=> !data_ready);
  assert_hold_read_R7: assert property (@(posedge clk) disable iff (rst)
    (!en_q && rd_en && !push_req && !ctrl_wr) |=> !data_ready);
  assert_tx_flush_R2: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && ctrl_wdata[CTL_TXRST]) |=> tx_flush);
endmodule

// File: tb/sim_uart_rx_buffer.sv
`timescale 1ns/1ps
module sim_uart_rx_buffer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctrl_wr = 1'b0;
  logic [2:0] ctrl_wdata = '0;
  logic [2:0] ctrl_rdata;
  logic tx_flush;
  logic rx_valid = 1'b0, rx_perr = 1'b0, rx_ferr = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_byte = '0;
  logic rd_en = 1'b0;
  logic [7:0] rd_data;
  logic rd_valid;
  logic [8:0] fifo_status;
  logic data_ready;
  logic err_rd = 1'b0;
  logic [3:0] err_rdata;
  logic rx_evt, err_evt;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_rx_buffer u0 (
    .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .tx_flush(tx_flush), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_break(rx_break),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .fifo_status(fifo_status),
    .data_ready(data_ready), .err_rd(err_rd), .err_rdata(err_rdata),
    .rx_evt(rx_evt), .err_evt(err_evt)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctrl(input logic [2:0] v);
    ctrl_wr = 1'b1; ctrl_wdata = v; step(); ctrl_wr = 1'b0; ctrl_wdata = '0;
  endtask

  task automatic push(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b; step(); rx_valid = 1'b0;
  endtask

  task automatic read();
    rd_en = 1'b1; step(); rd_en = 1'b0;
  endtask

  task automatic eread();
    err_rd = 1'b1; step(); err_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 ctrl", 16'(ctrl_rdata), 16'h0);
    check("R1 status", 16'(fifo_status), 16'h0);
    check("R1 ready", 16'(data_ready), 16'h0);
    check("R1 err", 16'(err_rdata), 16'h0);
    check("R1 events", 16'({rx_evt, err_evt, tx_flush}), 16'h0);
  endtask

  task automatic t_ctrl();
    ctrl(3'b101);
    check("R2 enable readback", 16'(ctrl_rdata), 16'h1);
    check("R2 tx flush pulse", 16'(tx_flush), 16'h1);
    step();
    check("R2 tx flush ends", 16'(tx_flush), 16'h0);
  endtask

  task automatic t_order();
    for (int i = 0; i < 5; i++) begin
      push(8'hA0 + 8'(i));
      check("R9 rx event", 16'(rx_evt), 16'h1);
    end
    check("R4 count five", 16'(fifo_status), 16'h005);
    check("R6 ready set", 16'(data_ready), 16'h1);
    for (int i = 0; i < 5; i++) begin
      read();
      check("R3 order", 16'({rd_valid, rd_data}), 16'({1'b1, 8'hA0 + 8'(i)}));
      check("R6 ready", 16'(data_ready), (i == 4) ? 16'h0 : 16'h1);
    end
    check("R4 count zero", 16'(fifo_status), 16'h0);
  endtask

  task automatic t_empty();
    eread();
    read();
    check("R5 zero data", 16'({rd_valid, rd_data}), 16'h100);
    check("R5 err event", 16'(err_evt), 16'h1);
    eread();
    check("R5 no status bit", 16'(err_rdata), 16'h0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 16; i++) push(8'hB0 + 8'(i));
    check("R4 full packing", 16'(fifo_status), 16'h100);
    push(8'hEE);
    check("R9 no rx event on drop", 16'(rx_evt), 16'h0);
    check("R8 err event", 16'(err_evt), 16'h1);
    check("R8 still full", 16'(fifo_status), 16'h100);
    eread();
    check("R8 overrun bit", 16'(err_rdata), 16'h1);
  endtask

  task automatic t_simul();
    read();
    check("R8 first kept", 16'(rd_data), 16'h00B0);
    check("R4 count 15", 16'(fifo_status), 16'h00F);
    rx_valid = 1'b1; rx_byte = 8'h77; rd_en = 1'b1; step(); rx_valid = 1'b0; rd_en = 1'b0;
    check("R13 pop data", 16'(rd_data), 16'h00B1);
    check("R13 count kept", 16'(fifo_status), 16'h00F);
    push(8'h78);
    check("R4 full again", 16'(fifo_status), 16'h100);
    rx_valid = 1'b1; rx_byte = 8'h79; rd_en = 1'b1; step(); rx_valid = 1'b0; rd_en = 1'b0;
    check("R13 full pop data", 16'(rd_data), 16'h00B2);
    check("R13 full accepted", 16'({rx_evt, err_evt}), 16'h2);
    check("R13 full count", 16'(fifo_status), 16'h100);
    ctrl(3'b011);
    check("R2 flush count", 16'(fifo_status), 16'h0);
    check("R2 flush ready", 16'(data_ready), 16'h0);
    check("R2 flush bits read 0", 16'(ctrl_rdata), 16'h1);
  endtask

  task automatic t_break();
    eread();
    rx_break = 1'b1; step(); rx_break = 1'b0;
    check("R10 events", 16'({rx_evt, err_evt}), 16'h3);
    check("R10 stored", 16'(fifo_status), 16'h001);
    eread();
    check("R10 break bit", 16'(err_rdata), 16'h8);
    read();
    check("R10 zero byte", 16'({rd_valid, rd_data}), 16'h100);
  endtask

  task automatic t_flags();
    rx_perr = 1'b1; push(8'h33); rx_perr = 1'b0;
    check("R11 parity events", 16'({rx_evt, err_evt}), 16'h3);
    eread();
    check("R11 parity bit", 16'(err_rdata), 16'h2);
    rx_ferr = 1'b1; push(8'h44); rx_ferr = 1'b0;
    eread();
    check("R11 frame bit", 16'(err_rdata), 16'h4);
    read();
    check("R11 byte kept a", 16'(rd_data), 16'h0033);
    read();
    check("R11 byte kept b", 16'(rd_data), 16'h0044);
  endtask

  task automatic t_clear();
    err_rd = 1'b1; rx_valid = 1'b1; rx_perr = 1'b1; rx_byte = 8'h55; step();
    err_rd = 1'b0; rx_valid = 1'b0; rx_perr = 1'b0;
    check("R12 old value", 16'(err_rdata), 16'h0);
    eread();
    check("R12 same-cycle kept", 16'(err_rdata), 16'h2);
    eread();
    check("R12 cleared", 16'(err_rdata), 16'h0);
    read();
    check("R12 drain", 16'(rd_data), 16'h0055);
  endtask

  task automatic t_hold();
    ctrl(3'b000);
    check("R7 disabled", 16'({ctrl_rdata, data_ready}), 16'h0);
    push(8'h11);
    check("R7 rx event", 16'(rx_evt), 16'h1);
    push(8'h22);
    check("R7 ready", 16'(data_ready), 16'h1);
    read();
    check("R7 latest byte", 16'({rd_valid, rd_data}), 16'h122);
    check("R7 ready cleared", 16'(data_ready), 16'h0);
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_ctrl();
    t_order();
    t_empty();
    t_full();
    t_simul();
    t_break();
    t_flags();
    t_clear();
    t_hold();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule